// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a 16-bit counter built from two 8-bit halves that carry into each other. It counts either machine cycles, where a machine cycle is a fixed number of oscillator clocks (12 by default), or falling edges on an external event pin. A second pin, the capture/reload strobe, feeds the capture function. Three control inputs pick the operating mode: a run bit, a capture-versus-reload select and a baud-clock select.

In auto-reload mode a wrap past FFFFH loads the count from the 16-bit companion register and raises the overflow flag for one cycle. In capture mode a falling edge on the strobe pin copies the live count into the companion register and raises a capture flag, while the count keeps running. In baud mode the count steps every second oscillator clock, and each wrap reloads it and emits a one-cycle baud tick. Software-style write ports load the count and the companion register directly.

Both pins pass through the same per-machine-cycle sampler. A pin is sampled on the last clock of each machine cycle, and an event requires a high sample followed by a low sample. So at most one event is seen every two machine cycles.

Top module: `tmr16_core`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, count_o and cr_o are 0 and ovf_o, baud_tick_o and cap_flag_o are 0.
- R2: With run_i=1, baud_sel_i=0 and src_sel_i=0, the count increments once every DIV=12 clocks. The increment happens at the clock edge that ends each machine cycle, and machine cycles are counted from reset release.
- R3: With src_sel_i=1 in a non-baud running mode, the count increments once for each pair of consecutive machine-cycle samples of ext_cnt_i that read 1 then 0. The new value appears one clock after the edge that takes the low sample. A level held for 12 clocks is always sampled.
- R4: With run_i=0 the count holds, no flag or tick is raised, and strobe edges do not alter cr_o. Only cnt_wr_i changes the count.
- R5: In auto-reload mode (run_i=1, baud_sel_i=0, cr_sel_i=0), an increment from FFFFH loads cr_o into the count and sets ovf_o for exactly one cycle.
- R6: In capture mode (run_i=1, baud_sel_i=0, cr_sel_i=1), a sampled falling edge on ext_cr_i copies the current count into cr_o and pulses cap_flag_o. The count runs on, and it wraps from FFFFH to 0000H with an ovf_o pulse.
- R7: In baud mode (run_i=1, baud_sel_i=1), the count increments on every second clock after reset, whatever src_sel_i says. An increment from FFFFH loads cr_o and pulses baud_tick_o for one cycle, and ovf_o stays 0.
- R8: cnt_wr_i loads cnt_wdata_i into the count at the next edge and takes priority over any increment or wrap. cr_wr_i loads cr_wdata_i into cr_o and takes priority over a capture, which then raises no flag.
- R9: In auto-reload and baud modes, edges on ext_cr_i leave cr_o unchanged and raise no cap_flag_o.
- R10: baud_sel_i=1 selects baud mode regardless of cr_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable |
| cr_sel_i | input | 1 | 1 = capture, 0 = auto-reload |
| baud_sel_i | input | 1 | 1 = baud-generator mode |
| src_sel_i | input | 1 | 1 = count external events, 0 = count machine cycles |
| ext_cnt_i | input | 1 | External event pin |
| ext_cr_i | input | 1 | Capture strobe pin |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| cr_wr_i | input | 1 | Capture/reload register write strobe |
| cr_wdata_i | input | 16 | Capture/reload write data |
| count_o | output | 16 | Current count |
| cr_o | output | 16 | Capture/reload register |
| ovf_o | output | 1 | One-cycle overflow pulse |
| cap_flag_o | output | 1 | One-cycle capture pulse |
| baud_tick_o | output | 1 | One-cycle baud tick |

## Verification
The assertions assume that every input is synchronous to clk_i, with no synchronizer stage in front of the pins. They also assume that the mode inputs and write strobes change only between edges. The bench drives all inputs on the falling clock edge. It holds each pin level for at least one machine cycle wherever an exact event count is expected, and uses faster toggling only where the reference model alone judges the result.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_RELOAD  = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_BAUD    = 2'd3
  } tmr_mode_e;

  function automatic tmr_mode_e decode_mode(input logic run, input logic baud, input logic cap);
    if (!run)      return MODE_OFF;
    else if (baud) return MODE_BAUD;
    else if (cap)  return MODE_CAPTURE;
    else           return MODE_RELOAD;
  endfunction

endpackage

// File: rtl/tmr16_mcycle.sv
module tmr16_mcycle #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mc_tick_o,
  output logic half_tick_o
);
  localparam int MC_W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [MC_W-1:0] mc_q;
  logic            half_q;

  assign mc_tick_o   = (mc_q == MC_W'(DIV - 1));
  assign half_tick_o = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q   <= '0;
      half_q <= 1'b0;
    end else begin
      mc_q   <= mc_tick_o ? '0 : mc_q + 1'b1;
      half_q <= ~half_q;
    end
  end

  // machine-cycle strobe never lasts two clocks
  assert_mc_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_tick_o |=> !mc_tick_o);

endmodule

// File: rtl/tmr16_fall.sv
module tmr16_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_en_i,
  input  logic pin_i,
  output logic fall_o
);
  logic smp_q;
  logic fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      fall_q <= smp_en_i & smp_q & ~pin_i;
      if (smp_en_i) smp_q <= pin_i;
    end
  end

  assign fall_o = fall_q;

  assert_fall_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  tmr_mode_e           mode_i,
  input  logic                inc_i,
  input  logic                cap_ev_i,
  input  logic                cnt_wr_i,
  input  logic [2*BYTE_W-1:0] cnt_wdata_i,
  input  logic                cr_wr_i,
  input  logic [2*BYTE_W-1:0] cr_wdata_i,
  output logic [2*BYTE_W-1:0] count_o,
  output logic [2*BYTE_W-1:0] cr_o,
  output logic                ovf_o,
  output logic                tick_o,
  output logic                flag_o
);
  localparam int NB    = 2;
  localparam int CNT_W = NB * BYTE_W;

  logic [NB-1:0][BYTE_W-1:0] byte_q, byte_nx;
  logic [NB:0]               cy;
  logic [CNT_W-1:0]          cr_q;
  logic                      wrap, cap_hit;
  logic                      ovf_q, tick_q, flag_q;

  assign cy[0] = inc_i;
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign byte_nx[g] = byte_q[g] + BYTE_W'(cy[g]);
    assign cy[g+1]    = cy[g] & (&byte_q[g]);
  end

  assign wrap    = cy[NB];
  assign cap_hit = cap_ev_i && (mode_i == MODE_CAPTURE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      ovf_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      ovf_q  <= !cnt_wr_i && wrap && (mode_i != MODE_BAUD);
      tick_q <= !cnt_wr_i && wrap && (mode_i == MODE_BAUD);
      if (cnt_wr_i)                     byte_q <= cnt_wdata_i;
      else if (wrap && mode_i == MODE_CAPTURE) byte_q <= '0;
      else if (wrap)                    byte_q <= cr_q;
      else                              byte_q <= byte_nx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= !cr_wr_i && cap_hit;
      if (cr_wr_i)      cr_q <= cr_wdata_i;
      else if (cap_hit) cr_q <= byte_q;
    end
  end

  assign count_o = byte_q;
  assign cr_o    = cr_q;
  assign ovf_o   = ovf_q;
  assign tick_o  = tick_q;
  assign flag_o  = flag_q;

  // captured value equals the count seen on the previous clock
  assert_cap_copy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> cr_o == $past(count_o));

  assert_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && $past(mode_i) == MODE_RELOAD) |-> count_o == $past(cr_o));

  assert_tick_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DIV    = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                cr_sel_i,
  input  logic                baud_sel_i,
  input  logic                src_sel_i,
  input  logic                ext_cnt_i,
  input  logic                ext_cr_i,
  input  logic                cnt_wr_i,
  input  logic [2*BYTE_W-1:0] cnt_wdata_i,
  input  logic                cr_wr_i,
  input  logic [2*BYTE_W-1:0] cr_wdata_i,
  output logic [2*BYTE_W-1:0] count_o,
  output logic [2*BYTE_W-1:0] cr_o,
  output logic                ovf_o,
  output logic                cap_flag_o,
  output logic                baud_tick_o
);
  localparam int NPIN = 2;

  tmr_mode_e       mode;
  logic            mc_tick, half_tick, inc;
  logic [NPIN-1:0] pins, falls;

  assign mode = decode_mode(run_i, baud_sel_i, cr_sel_i);

  tmr16_mcycle #(.DIV(DIV)) u_mcycle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mc_tick_o   (mc_tick),
    .half_tick_o (half_tick)
  );

  // index 0: event pin, index 1: capture strobe
  assign pins = {ext_cr_i, ext_cnt_i};
  for (genvar p = 0; p < NPIN; p++) begin : g_smp
    tmr16_fall u_fall (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .smp_en_i (mc_tick),
      .pin_i    (pins[p]),
      .fall_o   (falls[p])
    );
  end

  always_comb begin
    unique case (mode)
      MODE_OFF:  inc = 1'b0;
      MODE_BAUD: inc = half_tick;
      default:   inc = src_sel_i ? falls[0] : mc_tick;
    endcase
  end

  tmr16_count #(.BYTE_W(BYTE_W)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .inc_i       (inc),
    .cap_ev_i    (falls[1]),
    .cnt_wr_i    (cnt_wr_i),
    .cnt_wdata_i (cnt_wdata_i),
    .cr_wr_i     (cr_wr_i),
    .cr_wdata_i  (cr_wdata_i),
    .count_o     (count_o),
    .cr_o        (cr_o),
    .ovf_o       (ovf_o),
    .tick_o      (baud_tick_o),
    .flag_o      (cap_flag_o)
  );

  assert_off_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(count_o));

  assert_baud_no_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |-> !ovf_o);

endmodule

// File: tb/tmr16_core_bench.sv
module tmr16_core_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run = 0, cr_sel = 0, baud_sel = 0, src_sel = 0;
  logic        ext_cnt = 0, ext_cr = 0, cnt_wr = 0, cr_wr = 0;
  logic [15:0] cnt_wd = '0, cr_wd = '0;
  logic [15:0] count, cr;
  logic        ovf, cflag, btick;

  int checks = 0, errors = 0, cycles = 0;
  int n_ovf = 0, n_tick = 0, n_flag = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr16_core u_tmr16_core (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .cr_sel_i(cr_sel),
    .baud_sel_i(baud_sel), .src_sel_i(src_sel), .ext_cnt_i(ext_cnt),
    .ext_cr_i(ext_cr), .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wd),
    .cr_wr_i(cr_wr), .cr_wdata_i(cr_wd), .count_o(count), .cr_o(cr),
    .ovf_o(ovf), .cap_flag_o(cflag), .baud_tick_o(btick)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int        m_n = 0;
  int        m_cnt = 0, m_cr = 0;
  bit        m_ovf = 0, m_tick = 0, m_flag = 0;
  bit        s_cnt = 0, s_cr = 0, f_cnt = 0, f_cr = 0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_n = 0; m_cnt = 0; m_cr = 0; m_ovf = 0; m_tick = 0; m_flag = 0;
      s_cnt = 0; s_cr = 0; f_cnt = 0; f_cr = 0;
    end else begin
      bit mc_end, inc, is_baud, is_cap;
      int old_cnt, old_cr;
      mc_end  = (m_n % 12) == 11;
      is_baud = run && baud_sel;
      is_cap  = run && !baud_sel && cr_sel;
      if (!run)         inc = 0;
      else if (is_baud) inc = (m_n % 2) == 1;
      else              inc = src_sel ? f_cnt : mc_end;
      old_cnt = m_cnt; old_cr = m_cr;
      m_ovf = 0; m_tick = 0; m_flag = 0;
      if (cnt_wr) m_cnt = cnt_wd;
      else if (inc) begin
        if (old_cnt == 'hFFFF) begin
          if (is_baud) begin m_cnt = old_cr; m_tick = 1; end
          else begin m_cnt = is_cap ? 0 : old_cr; m_ovf = 1; end
        end else m_cnt = old_cnt + 1;
      end
      if (cr_wr) m_cr = cr_wd;
      else if (is_cap && f_cr) begin m_cr = old_cnt; m_flag = 1; end
      f_cnt = mc_end && s_cnt && !ext_cnt;
      f_cr  = mc_end && s_cr && !ext_cr;
      if (mc_end) begin s_cnt = ext_cnt; s_cr = ext_cr; end
      m_n++;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_ni && !done) begin
      check("R2 count", count, m_cnt);
      check("R6 cr", cr, m_cr);
      check("R5 ovf", ovf, m_ovf);
      check("R7 tick", btick, m_tick);
      check("R6 flag", cflag, m_flag);
      n_ovf += ovf; n_tick += btick; n_flag += cflag;
    end
  end

  task automatic cyc(int k); repeat (k) @(negedge clk); endtask
  task automatic wr_cnt(logic [15:0] v); cnt_wd = v; cnt_wr = 1; cyc(1); cnt_wr = 0; endtask
  task automatic wr_cr(logic [15:0] v); cr_wd = v; cr_wr = 1; cyc(1); cr_wr = 0; endtask
  task automatic clr_seen(); n_ovf = 0; n_tick = 0; n_flag = 0; endtask

  initial begin
    logic [15:0] snap;
    cyc(3);
    check("R1 count in reset", count, 0);
    check("R1 flags in reset", {ovf, cflag, btick}, 0);
    rst_ni = 1;
    cyc(1);
    check("R1 count after reset", count, 0);
    check("R1 cr after reset", cr, 0);

    // R2: machine-cycle timer
    run = 1;
    wr_cnt(16'h0000);
    cyc(120);
    check("R2 ten machine cycles", (count >= 9 && count <= 11), 1);

    // R5: auto-reload wrap
    wr_cr(16'h1234);
    wr_cnt(16'hFFF0);
    clr_seen();
    cyc(17 * 12 + 4);
    check("R5 one overflow", n_ovf, 1);
    check("R5 reloaded", (count >= 16'h1234 && count <= 16'h1236), 1);

    // R3: event counting with slow levels
    src_sel = 1;
    wr_cnt(16'h0000);
    for (int i = 0; i < 10; i++) begin
      ext_cnt = 1; cyc(12); ext_cnt = 0; cyc(12);
    end
    cyc(30);
    check("R3 ten events", count, 10);
    for (int i = 0; i < 40; i++) begin
      ext_cnt = ~ext_cnt; cyc(3 + (i % 5));
    end
    ext_cnt = 0;
    cyc(30);

    // R9: strobe ignored in auto-reload
    src_sel = 0;
    snap = cr;
    clr_seen();
    for (int i = 0; i < 3; i++) begin
      ext_cr = 1; cyc(24); ext_cr = 0; cyc(24);
    end
    check("R9 cr unchanged in reload", cr, snap);
    check("R9 no capture flag", n_flag, 0);

    // R6: capture mode
    cr_sel = 1;
    clr_seen();
    ext_cr = 1; cyc(24); ext_cr = 0; cyc(30);
    check("R6 one capture", n_flag, 1);
    wr_cnt(16'hFFFE);
    clr_seen();
    cyc(40);
    check("R6 wrap to zero with ovf", n_ovf, 1);
    check("R6 count after wrap", count <= 16'h0002, 1);
    // R8: write beats capture
    ext_cr = 1; cyc(24); ext_cr = 0;
    for (int i = 0; i < 14; i++) begin cr_wd = 16'hBEEF; cr_wr = 1; cyc(1); end
    cr_wr = 0;
    cyc(2);
    check("R8 cr write wins", cr, 16'hBEEF);

    // R4: off
    run = 0;
    snap = count;
    clr_seen();
    src_sel = 1;
    for (int i = 0; i < 6; i++) begin
      ext_cnt = 1; ext_cr = 1; cyc(12); ext_cnt = 0; ext_cr = 0; cyc(12);
    end
    check("R4 count held", count, snap);
    check("R4 nothing raised", n_ovf + n_tick + n_flag, 0);
    check("R4 cr held", cr, 16'hBEEF);

    // R7/R10: baud mode with capture select also high and event source
    run = 1; baud_sel = 1;
    wr_cr(16'hFFF0);
    wr_cnt(16'hFFF0);
    clr_seen();
    for (int i = 0; i < 4; i++) begin
      ext_cr = 1; cyc(24); ext_cr = 0; cyc(24);
    end
    check("R7 ticks seen", n_tick >= 5, 1);
    check("R7 no ovf in baud", n_ovf, 0);
    check("R10 baud wins over capture", n_flag, 0);
    check("R9 cr unchanged in baud", cr, 16'hFFF0);

    // R8: count write beats increment
    wr_cnt(16'h0005);
    check("R8 count write", count, 16'h0005);
    cyc(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule